// File: doc/BRIEF.md
# Interleaved SAR phase sequencer

This block produces the control timing for a bank of time-interleaved successive-approximation converter sections that all run from one clock. Every section steps through the same repeating sixteen-clock schedule. It samples a zero reference, then makes an offset comparison and a gain comparison. It then samples the analog input, makes eleven bit decisions most significant bit first, and hands its word over. Each section runs one clock behind the section before it, so that one section samples the input on every clock.

The block receives one comparator decision per section. For each section it returns the trial code that the section's DAC must present, one-clock strobes for the zero-reference and input-sample phases, and one-clock strobes carrying the offset and gain comparator results to external integrators. A single shared output register collects each finished word. It presents the word with a valid strobe and the index of the section that produced it, one word per clock in strict round-robin order.

Top module: `sarseq_top`

## Requirements
- R1: A free-running phase counter resets to 0 and advances by one per clock modulo 16. Section s is in phase index (k - s) mod 16, where k counts clock edges since reset was released and index 0 is phase 1. `zero_smp_o` is one-hot on section k mod 16, and `xfer_o` is one-hot on section (k - 15) mod 16.
- R2: On every clock exactly one bit of `sample_o` is set. It is the bit of section (k - 3) mod 16, which is in phase 4 (input sample).
- R3: When a section is in phase 2 (offset compare), its comparator bit is captured. In the next clock that section's `az_vld_o` bit is high for one cycle and its `az_bit_o` bit carries the captured value. All other sections' `az_vld_o` bits are low.
- R4: When a section is in phase 3 (gain compare), its comparator bit is captured in the same way. In the next clock that section's `cal_vld_o` bit is high for one cycle and its `cal_bit_o` bit carries the value.
- R5: Phases 5 to 15 decide bits 10 down to 0, one bit per phase. During a bit phase the section's DAC code is the bits decided so far with the current bit set, so phase 5 presents 1024. A comparator value of 1 at the end of the phase keeps the bit and 0 clears it. In all other phases the DAC code is 0, and a bit phase changes no bit other than its own.
- R6: With a comparator that reports 1 when the held input is at least the DAC code, the result equals the held input for every code from 0 to 2047.
- R7: A word sampled in the clock that ends at edge E appears on `res_o` after edge E+12, together with `res_vld_o` and the index of its section on `res_sect_o`.
- R8: While `res_vld_o` is high, `res_sect_o` advances by one modulo 16 on every clock, and in clock k it equals k mod 16.
- R9: Any conversion that was already in progress at reset is discarded. `res_vld_o` is low for the first 16 clocks after reset. It rises after the 16th edge, carrying section 0, and then stays high on every clock.
- R10: While reset is asserted, `res_vld_o`, `az_vld_o` and `cal_vld_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 16 | Comparator decision, one bit per section |
| zero_smp_o | output | 16 | Per-section strobe for the zero-reference sample phase |
| sample_o | output | 16 | Per-section strobe for the input-sample phase |
| xfer_o | output | 16 | Per-section strobe for the data-transfer phase |
| az_vld_o | output | 16 | Per-section strobe for the offset comparison result |
| az_bit_o | output | 16 | Captured offset comparator bit per section |
| cal_vld_o | output | 16 | Per-section strobe for the gain comparison result |
| cal_bit_o | output | 16 | Captured gain comparator bit per section |
| dac_code_o | output | 176 | Trial DAC code per section, 11 bits each, section s at bits s*11 upward |
| res_o | output | 11 | Finished conversion word |
| res_vld_o | output | 1 | One word is present on res_o in this clock |
| res_sect_o | output | 4 | Section that produced res_o |

## Verification
The assertions assume a synchronous reset that is held across at least one clock edge. They also assume that each `cmp_i` bit is settled before the edge that samples it. Under those assumptions the round-robin order, the single active sampler and the one-bit-per-phase change hold whatever the comparator values are. The bench computes the comparators from a behavioural model. In each section's bit phases, that model compares the section's held input against the DAC code the section presents. In every other phase it drives a known pseudo-random bit. Every change the bench makes happens on the falling edge, so each comparator value is stable at the rising edge that samples it.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

   // Kind of work a section performs in its current phase
   typedef enum logic [2:0] {
      K_REFZ,
      K_AZ,
      K_CAL,
      K_SMP,
      K_BIT,
      K_XFER
   } phase_kind_t;

   // Fixed phase positions ahead of the bit decisions
   localparam int PH_REFZ = 0;
   localparam int PH_AZ   = 1;
   localparam int PH_CAL  = 2;
   localparam int PH_SMP  = 3;
   localparam int PH_BIT0 = 4;

   // Schedule length for a given resolution
   function automatic int cycle_len(input int res_bits);
      return res_bits + 5;
   endfunction

   // Index of the transfer phase for a given resolution
   function automatic int xfer_phase(input int res_bits);
      return res_bits + PH_BIT0;
   endfunction

endpackage

// File: rtl/sarseq_timebase.sv
module sarseq_timebase #(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst,
   output logic [PW-1:0] cnt_o
);

   if (PW < 1) begin : g_bad_pw
      $error("sarseq_timebase: PW must be at least 1");
   end

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R1: the counter never skips a value
   assert_step_R1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sarseq_section.sv
module sarseq_section
   import sarseq_pkg::*;
#(
   parameter int W               = 11,
   parameter int PW              = 4,
   parameter int SECT_ID         = 0,
   parameter bit CMP_ACTIVE_HIGH = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] cnt_i,
   input  logic          cmp_i,
   output logic          zero_smp_o,
   output logic          sample_o,
   output logic          xfer_o,
   output logic          az_vld_o,
   output logic          az_bit_o,
   output logic          cal_vld_o,
   output logic          cal_bit_o,
   output logic          started_o,
   output logic [W-1:0]  dac_o,
   output logic [W-1:0]  word_o
);

   localparam int LAST_BIT_PH = PH_BIT0 + W - 1;
   localparam int XFER_PH     = xfer_phase(W);

   if (XFER_PH >= (1 << PW)) begin : g_bad_len
      $error("sarseq_section: schedule does not fit the phase counter");
   end

   logic [PW-1:0] ph;
   phase_kind_t   kind;
   logic [W-1:0]  trial_bit;
   logic [W-1:0]  acc_q;
   logic          keep;
   logic          started_q;
   logic          az_vld_q, az_bit_q, cal_vld_q, cal_bit_q;

   assign ph = cnt_i - PW'(SECT_ID);

   always_comb begin
      kind = K_XFER;
      if (ph == PW'(PH_REFZ))                                 kind = K_REFZ;
      else if (ph == PW'(PH_AZ))                              kind = K_AZ;
      else if (ph == PW'(PH_CAL))                             kind = K_CAL;
      else if (ph == PW'(PH_SMP))                             kind = K_SMP;
      else if (ph >= PW'(PH_BIT0) && ph <= PW'(LAST_BIT_PH))  kind = K_BIT;
   end

   // One-hot trial bit: phase PH_BIT0 selects the MSB
   for (genvar i = 0; i < W; i++) begin : g_trial
      assign trial_bit[i] = (ph == PW'(PH_BIT0 + W - 1 - i));
   end

   // Comparator polarity variant
   if (CMP_ACTIVE_HIGH) begin : g_pol_hi
      assign keep = cmp_i;
   end else begin : g_pol_lo
      assign keep = ~cmp_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= '0;
         started_q <= 1'b0;
         az_vld_q  <= 1'b0;
         az_bit_q  <= 1'b0;
         cal_vld_q <= 1'b0;
         cal_bit_q <= 1'b0;
      end else begin
         if (kind == K_SMP) acc_q <= '0;
         else if (kind == K_BIT && keep) acc_q <= acc_q | trial_bit;
         if (kind == K_REFZ) started_q <= 1'b1;
         az_vld_q  <= (kind == K_AZ);
         cal_vld_q <= (kind == K_CAL);
         if (kind == K_AZ)  az_bit_q  <= cmp_i;
         if (kind == K_CAL) cal_bit_q <= cmp_i;
      end
   end

   assign zero_smp_o = (kind == K_REFZ);
   assign sample_o   = (kind == K_SMP);
   assign xfer_o     = (kind == K_XFER);
   assign az_vld_o   = az_vld_q;
   assign az_bit_o   = az_bit_q;
   assign cal_vld_o  = cal_vld_q;
   assign cal_bit_o  = cal_bit_q;
   assign started_o  = started_q;
   assign dac_o      = (kind == K_BIT) ? (acc_q | trial_bit) : '0;
   assign word_o     = acc_q;

   // R5: a bit phase may alter only its own bit of the running word
   assert_own_bit_R5: assert property (@(posedge clk) disable iff (rst)
      (kind == K_BIT) |=> (((acc_q ^ $past(acc_q)) & ~$past(trial_bit)) == '0));

   // R5: the running word is empty when the first decision begins
   assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (kind == K_SMP) |=> (acc_q == '0));

endmodule

// File: rtl/sarseq_collect.sv
module sarseq_collect #(
   parameter int N  = 16,
   parameter int W  = 11,
   parameter int SW = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N-1:0]   xfer_i,
   input  logic [N-1:0]   started_i,
   input  logic [N*W-1:0] words_i,
   output logic [W-1:0]   res_o,
   output logic           res_vld_o,
   output logic [SW-1:0]  res_sect_o
);

   if ((1 << SW) < N) begin : g_bad_sw
      $error("sarseq_collect: SW too narrow for N");
   end

   logic [W-1:0]  word_sel;
   logic [SW-1:0] idx_sel;
   logic          ok_sel;
   logic [W-1:0]  res_q;
   logic          vld_q;
   logic [SW-1:0] sect_q;

   always_comb begin
      word_sel = '0;
      idx_sel  = '0;
      ok_sel   = 1'b0;
      for (int s = 0; s < N; s++) begin
         if (xfer_i[s]) begin
            word_sel = word_sel | words_i[s*W +: W];
            idx_sel  = idx_sel | SW'(s);
            ok_sel   = ok_sel | started_i[s];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= '0;
         vld_q  <= 1'b0;
         sect_q <= '0;
      end else begin
         res_q  <= word_sel;
         vld_q  <= ok_sel;
         sect_q <= idx_sel;
      end
   end

   assign res_o      = res_q;
   assign res_vld_o  = vld_q;
   assign res_sect_o = sect_q;

   // R7: exactly one section hands over its word in each clock
   assert_one_xfer_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot(xfer_i));

   // R8: consecutive words come from consecutive sections
   assert_order_R8: assert property (@(posedge clk) disable iff (rst)
      (res_vld_o && $past(res_vld_o)) |-> (res_sect_o == $past(res_sect_o) + 1'b1));

   // R9: once valid, the output keeps producing a word every clock
   assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      res_vld_o |=> res_vld_o);

endmodule

// File: rtl/sarseq_top.sv
module sarseq_top
   import sarseq_pkg::*;
#(
   parameter int N               = 16,
   parameter int W               = 11,
   parameter bit CMP_ACTIVE_HIGH = 1'b1,
   localparam int PW             = $clog2(N),
   localparam int SW             = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N-1:0]   cmp_i,
   output logic [N-1:0]   zero_smp_o,
   output logic [N-1:0]   sample_o,
   output logic [N-1:0]   xfer_o,
   output logic [N-1:0]   az_vld_o,
   output logic [N-1:0]   az_bit_o,
   output logic [N-1:0]   cal_vld_o,
   output logic [N-1:0]   cal_bit_o,
   output logic [N*W-1:0] dac_code_o,
   output logic [W-1:0]   res_o,
   output logic           res_vld_o,
   output logic [SW-1:0]  res_sect_o
);

   if (W < 2) begin : g_bad_w
      $error("sarseq_top: W must be at least 2");
   end
   if (cycle_len(W) != N) begin : g_bad_n
      $error("sarseq_top: section count must equal schedule length W+5");
   end
   if ((1 << PW) != N) begin : g_bad_pow
      $error("sarseq_top: section count must be a power of two");
   end

   logic [PW-1:0]  cnt;
   logic [N-1:0]   started;
   logic [N*W-1:0] words;

   sarseq_timebase #(.PW(PW)) u_tb (
      .clk   (clk),
      .rst   (rst),
      .cnt_o (cnt)
   );

   for (genvar s = 0; s < N; s++) begin : g_sect
      sarseq_section #(
         .W               (W),
         .PW              (PW),
         .SECT_ID         (s),
         .CMP_ACTIVE_HIGH (CMP_ACTIVE_HIGH)
      ) u_sect (
         .clk        (clk),
         .rst        (rst),
         .cnt_i      (cnt),
         .cmp_i      (cmp_i[s]),
         .zero_smp_o (zero_smp_o[s]),
         .sample_o   (sample_o[s]),
         .xfer_o     (xfer_o[s]),
         .az_vld_o   (az_vld_o[s]),
         .az_bit_o   (az_bit_o[s]),
         .cal_vld_o  (cal_vld_o[s]),
         .cal_bit_o  (cal_bit_o[s]),
         .started_o  (started[s]),
         .dac_o      (dac_code_o[s*W +: W]),
         .word_o     (words[s*W +: W])
      );
   end

   sarseq_collect #(.N(N), .W(W), .SW(SW)) u_col (
      .clk        (clk),
      .rst        (rst),
      .xfer_i     (xfer_o),
      .started_i  (started),
      .words_i    (words),
      .res_o      (res_o),
      .res_vld_o  (res_vld_o),
      .res_sect_o (res_sect_o)
   );

   // R2: a single section samples the input on every clock
   assert_one_sample_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot(sample_o));

   // R3: offset results never overlap between sections
   assert_az_single_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(az_vld_o));

   // R4: gain results never overlap between sections
   assert_cal_single_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cal_vld_o));

endmodule

// File: tb/sarseq_top_test.sv
module sarseq_top_test;

   localparam int N = 16;
   localparam int W = 11;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [N-1:0]   cmp;
   logic [N-1:0]   zero_smp, sample, xfer, az_vld, az_bit, cal_vld, cal_bit;
   logic [N*W-1:0] dac;
   logic [W-1:0]   res;
   logic           res_vld;
   logic [3:0]     res_sect;

   int n_chk = 0;
   int n_bad = 0;
   int k = 0;
   int mode = 0;
   logic [W-1:0] held [N];
   logic [N-1:0] snap;

   always #2 clk = ~clk;

   sarseq_top uut (
      .clk        (clk),
      .rst        (rst),
      .cmp_i      (cmp),
      .zero_smp_o (zero_smp),
      .sample_o   (sample),
      .xfer_o     (xfer),
      .az_vld_o   (az_vld),
      .az_bit_o   (az_bit),
      .cal_vld_o  (cal_vld),
      .cal_bit_o  (cal_bit),
      .dac_code_o (dac),
      .res_o      (res),
      .res_vld_o  (res_vld),
      .res_sect_o (res_sect)
   );

   function automatic int phase_of(int kk, int s);
      return (kk - s) & 15;
   endfunction

   function automatic logic [W-1:0] stim(int kk);
      case (mode)
         0:       return W'((kk * 37 + 5) & 2047);
         1:       return '0;
         2:       return '1;
         3:       return (kk % 2 == 0) ? W'(0) : W'(2047);
         default: return W'(2047 - ((kk * 53) & 2047));
      endcase
   endfunction

   // Behavioural comparators
   always_comb begin
      for (int s = 0; s < N; s++) begin
         int p;
         p = phase_of(k, s);
         if (p >= 4 && p <= 14) cmp[s] = (held[s] >= dac[s*W +: W]);
         else                   cmp[s] = 1'(((k * 7 + s * 3) >> 1) & 1);
      end
   end

   always @(posedge clk) snap <= cmp;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
      end
   endtask

   task automatic check_cycle();
      int s_az, s_cal, s_out;
      check(zero_smp == N'(1) << (k & 15), "R1 zero-ref strobe", int'(zero_smp), 1 << (k & 15));
      check(xfer == N'(1) << ((k - 15) & 15), "R1 transfer strobe", int'(xfer), 1 << ((k - 15) & 15));
      check(sample == N'(1) << ((k - 3) & 15), "R2 sample strobe", int'(sample), 1 << ((k - 3) & 15));
      s_az  = (k - 2) & 15;
      s_cal = (k - 3) & 15;
      if (k == 0) begin
         check(az_vld == '0, "R3 offset strobe after reset", int'(az_vld), 0);
         check(cal_vld == '0, "R4 gain strobe after reset", int'(cal_vld), 0);
      end else begin
         check(az_vld == N'(1) << s_az, "R3 offset strobe", int'(az_vld), 1 << s_az);
         check(az_bit[s_az] == snap[s_az], "R3 offset bit", int'(az_bit[s_az]), int'(snap[s_az]));
         check(cal_vld == N'(1) << s_cal, "R4 gain strobe", int'(cal_vld), 1 << s_cal);
         check(cal_bit[s_cal] == snap[s_cal], "R4 gain bit", int'(cal_bit[s_cal]), int'(snap[s_cal]));
      end
      check(dac[((k - 4) & 15) * W +: W] == W'(1024), "R5 first trial code",
            int'(dac[((k - 4) & 15) * W +: W]), 1024);
      check(dac[(k & 15) * W +: W] == '0, "R5 idle DAC code", int'(dac[(k & 15) * W +: W]), 0);
      if (k < 16) begin
         check(res_vld == 1'b0, "R9 no early valid", int'(res_vld), 0);
      end else begin
         s_out = k & 15;
         check(res_vld == 1'b1, "R9 valid every clock", int'(res_vld), 1);
         check(res_sect == 4'(s_out), "R8 section order", int'(res_sect), s_out);
         // R6 exact code, R7 sample taken 13 falling edges earlier
         check(res == held[s_out], "R6 R7 result code", int'(res), int'(held[s_out]));
      end
   endtask

   task automatic capture();
      int s;
      s = (k - 3) & 15;
      held[s] = stim(k);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(res_vld == 1'b0, "R10 reset valid", int'(res_vld), 0);
      check(az_vld == '0, "R10 reset offset strobe", int'(az_vld), 0);
      check(cal_vld == '0, "R10 reset gain strobe", int'(cal_vld), 0);
      rst = 1'b0;
      k = 0;
      check_cycle();
      capture();
   endtask

   task automatic run_pattern(input int m, input int cycles, input string name);
      mode = m;
      $display("scenario %s", name);
      do_reset();
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         k++;
         check_cycle();
         capture();
      end
   endtask

   task automatic test_ramp_up();     run_pattern(0, 120, "ramp up");         endtask
   task automatic test_zero();        run_pattern(1, 60,  "all zero");        endtask
   task automatic test_full();        run_pattern(2, 60,  "full scale");      endtask
   task automatic test_alternate();   run_pattern(3, 80,  "alternating");     endtask
   task automatic test_ramp_down();   run_pattern(4, 120, "ramp down");       endtask

   initial begin
      for (int s = 0; s < N; s++) held[s] = '0;
      test_ramp_up();
      test_zero();
      test_full();
      test_alternate();
      test_ramp_down();
      // R9: a reset in mid-run discards conversions again
      test_ramp_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule